// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block lets a host reach the management registers of external PHYs through indirect, two-step Clause 45 accesses. The host sees four 32-bit registers on a plain write/read-select port. The first access in a sequence selects the PHY and the device inside it. The next access loads a register address, and that load sends an address frame. After that, the host either writes a value, which sends a write frame, or sets a command bit, which sends a read frame. The block generates the management clock from the system clock. It serializes each frame onto the data line, and during a read it hands the line over to the PHY.

Two busy flags tell the host when it may continue. One sits in the status register and covers address frames. The other sits in the data register and covers write and read frames. When a read completes, the captured word appears in the data register. If no device answered, a read-error flag is raised instead, and software is expected to substitute all ones. The host port is a register port, not a stream, so it has no valid/ready handshake. While a frame is on the wire, every host write is discarded. The host must poll a busy flag before it issues the next access.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset the status register (index 0) reads busy bit 0 = 0, error bit 1 = 0 and divider field bits [15:8] = DIV_RST. The data-register busy bit 31 is 0. `mdc` and `mdio_oe` are low.
- R2: A host write to index 2 (register address) while idle sends a frame with opcode 00 that carries `host_wdata[15:0]` and the stored PHY and device addresses. Status bit 0 reads 1 from the cycle after the write until the frame ends.
- R3: A host write to index 3 (data) while idle sends a frame with opcode 01 that carries `host_wdata[15:0]`. Data-register bit 31 reads 1 until that frame ends.
- R4: A host write to index 1 (control) with bit 31 set sends a frame with opcode 11. The PHY address comes from bits [4:0] and the device address from bits [20:16]. Data-register bit 31 reads 1 until the frame ends, after which data bits [15:0] hold the 16 bits sampled from the PHY, most significant first.
- R5: Every frame is 64 bits: 32 ones, start 00, opcode, 5-bit PHY address, 5-bit device address, 2 turnaround bits, 16 payload bits, each field most significant bit first. Address and write frames drive turnaround as 10.
- R6: `mdc` has a period of 2×(divider+1) system clocks, each half lasting divider+1 clocks, and it stays low whenever no frame is in progress.
- R7: The driven `mdio_o` value changes only in the cycle where `mdc` has just fallen.
- R8: In a read frame, `mdio_oe` is low for the two turnaround bits and the 16 data bits.
- R9: A read whose second turnaround bit is sampled high sets status bit 1. The bit reads 0 from the start of the next read frame, and after a read that completes normally it stays 0.
- R10: Host writes to any register made while a frame is in progress have no effect. They change no register contents and start no frame.
- R11: A write to the status register while idle loads the divider field from bits [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe, one cycle per write |
| host_addr | input | 2 | Register index: 0 status, 1 control, 2 register address, 3 data |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Contents of the indexed register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the block |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Management data as seen on the line |

## Verification
The hardest situation to reach from the ports is a read that no device answers. The bench's PHY model stays silent for PHY address 31, so a pull-up leaves the second turnaround bit high. Clearing of the flag is then shown by reading status while the following read to a present PHY is still busy. Discarded accesses are also hard to observe, because they must land inside a frame. The bench issues writes to every register right after a start, then checks the register readback and the number of frames the PHY model saw.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;
  localparam int HOST_W    = 32;
  localparam int PRE_LEN   = 32;
  localparam int ST_W      = 2;
  localparam int OP_W      = 2;
  localparam int PHYAD_W   = 5;
  localparam int DEVAD_W   = 5;
  localparam int TA_W      = 2;
  localparam int PAY_W     = 16;
  localparam int FRAME_LEN = PRE_LEN + ST_W + OP_W + PHYAD_W + DEVAD_W + TA_W + PAY_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TA1_IDX   = PRE_LEN + ST_W + OP_W + PHYAD_W + DEVAD_W;
  localparam int TA2_IDX   = TA1_IDX + 1;
  localparam int PAY_IDX   = TA1_IDX + TA_W;

  // host register bit positions
  localparam int ST_BUSY_BIT   = 0;
  localparam int ST_ERR_BIT    = 1;
  localparam int ST_DIV_LSB    = 8;
  localparam int CTL_PA_LSB    = 0;
  localparam int CTL_DA_LSB    = 16;
  localparam int CTL_RD_BIT    = 31;
  localparam int DATA_BUSY_BIT = 31;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b11
  } mdio_op_e;

  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_CTRL   = 2'd1,
    REG_RADDR  = 2'd2,
    REG_DATA   = 2'd3
  } host_reg_e;
endpackage

// File: rtl/mdio_c45_clkgen.sv
module mdio_c45_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = run && (cnt_q == div);
  assign rise = wrap && !mdc;
  assign fall = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_c45_frame.sv
module mdio_c45_frame
  import mdio_c45_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  mdio_op_e           start_op,
  input  logic [PHYAD_W-1:0] start_pa,
  input  logic [DEVAD_W-1:0] start_da,
  input  logic [PAY_W-1:0]   start_pay,
  input  logic               tick_rise,
  input  logic               tick_fall,
  input  logic               mdio_i,
  output logic               active,
  output mdio_op_e           cur_op,
  output logic [IDX_W-1:0]   bit_idx,
  output logic               done,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic [PAY_W-1:0]   rd_word,
  output logic               ta_bad
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA1_I    = IDX_W'(TA1_IDX);
  localparam logic [IDX_W-1:0] TA2_I    = IDX_W'(TA2_IDX);
  localparam logic [IDX_W-1:0] PAY_I    = IDX_W'(PAY_IDX);

  logic [FRAME_LEN-1:0] shreg_q;
  logic [FRAME_LEN-1:0] frame_w;

  assign frame_w = {{PRE_LEN{1'b1}}, 2'b00, start_op, start_pa, start_da, 2'b10, start_pay};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      shreg_q <= '0;
      bit_idx <= '0;
      cur_op  <= OP_ADDR;
      rd_word <= '0;
      ta_bad  <= 1'b0;
    end else if (start && !active) begin
      active  <= 1'b1;
      shreg_q <= frame_w;
      bit_idx <= '0;
      cur_op  <= start_op;
      rd_word <= '0;
      ta_bad  <= 1'b0;
    end else if (active) begin
      if (tick_rise && cur_op == OP_READ) begin
        if (bit_idx == TA2_I) ta_bad <= mdio_i;
        if (bit_idx >= PAY_I) rd_word <= {rd_word[PAY_W-2:0], mdio_i};
      end
      if (tick_fall) begin
        if (bit_idx == LAST_IDX) begin
          active <= 1'b0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          shreg_q <= {shreg_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  assign done    = active && tick_fall && (bit_idx == LAST_IDX);
  assign mdio_o  = shreg_q[FRAME_LEN-1];
  assign mdio_oe = active && !(cur_op == OP_READ && bit_idx >= TA1_I);
endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
  import mdio_c45_pkg::*;
#(
  parameter int               DIV_W   = 8,
  parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [1:0]        host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [DIV_W-1:0]   div_q;
  logic [PHYAD_W-1:0] pa_q;
  logic [DEVAD_W-1:0] da_q;
  logic [PAY_W-1:0]   raddr_q;
  logic [PAY_W-1:0]   data_q;
  logic               err_q;

  logic               eng_active, eng_done, eng_ta_bad;
  mdio_op_e           eng_op;
  logic [IDX_W-1:0]   eng_idx;
  logic [PAY_W-1:0]   eng_rd;
  logic               tick_rise, tick_fall;

  logic               go;
  mdio_op_e           go_op;
  logic [PHYAD_W-1:0] go_pa;
  logic [DEVAD_W-1:0] go_da;
  logic [PAY_W-1:0]   go_pay;
  logic               host_ok;
  logic               stat_busy, data_busy;

  assign host_ok   = host_wr && !eng_active;
  assign stat_busy = eng_active && (eng_op == OP_ADDR);
  assign data_busy = eng_active && (eng_op != OP_ADDR);

  always_comb begin
    go     = 1'b0;
    go_op  = OP_ADDR;
    go_pa  = pa_q;
    go_da  = da_q;
    go_pay = raddr_q;
    if (host_ok) begin
      case (host_reg_e'(host_addr))
        REG_RADDR: begin go = 1'b1; go_op = OP_ADDR;  go_pay = host_wdata[PAY_W-1:0]; end
        REG_DATA:  begin go = 1'b1; go_op = OP_WRITE; go_pay = host_wdata[PAY_W-1:0]; end
        REG_CTRL: begin
          go    = host_wdata[CTL_RD_BIT];
          go_op = OP_READ;
          go_pa = host_wdata[CTL_PA_LSB +: PHYAD_W];
          go_da = host_wdata[CTL_DA_LSB +: DEVAD_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= DIV_RST;
      pa_q    <= '0;
      da_q    <= '0;
      raddr_q <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      if (eng_done && eng_op == OP_READ) begin
        data_q <= eng_rd;
        err_q  <= eng_ta_bad;
      end
      if (host_ok) begin
        case (host_reg_e'(host_addr))
          REG_STATUS: div_q <= host_wdata[ST_DIV_LSB +: DIV_W];
          REG_CTRL: begin
            pa_q <= host_wdata[CTL_PA_LSB +: PHYAD_W];
            da_q <= host_wdata[CTL_DA_LSB +: DEVAD_W];
            if (host_wdata[CTL_RD_BIT]) err_q <= 1'b0;
          end
          REG_RADDR: raddr_q <= host_wdata[PAY_W-1:0];
          REG_DATA:  data_q  <= host_wdata[PAY_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_reg_e'(host_addr))
      REG_STATUS: begin
        host_rdata[ST_BUSY_BIT]           = stat_busy;
        host_rdata[ST_ERR_BIT]            = err_q;
        host_rdata[ST_DIV_LSB +: DIV_W]   = div_q;
      end
      REG_CTRL: begin
        host_rdata[CTL_PA_LSB +: PHYAD_W] = pa_q;
        host_rdata[CTL_DA_LSB +: DEVAD_W] = da_q;
      end
      REG_RADDR: host_rdata[PAY_W-1:0] = raddr_q;
      REG_DATA: begin
        host_rdata[PAY_W-1:0]     = data_q;
        host_rdata[DATA_BUSY_BIT] = data_busy;
      end
      default: ;
    endcase
  end

  mdio_c45_clkgen #(.DIV_W(DIV_W)) clk_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (eng_active),
    .div  (div_q),
    .mdc  (mdc),
    .rise (tick_rise),
    .fall (tick_fall)
  );

  mdio_c45_frame eng_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (go),
    .start_op (go_op),
    .start_pa (go_pa),
    .start_da (go_da),
    .start_pay(go_pay),
    .tick_rise(tick_rise),
    .tick_fall(tick_fall),
    .mdio_i   (mdio_i),
    .active   (eng_active),
    .cur_op   (eng_op),
    .bit_idx  (eng_idx),
    .done     (eng_done),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_word  (eng_rd),
    .ta_bad   (eng_ta_bad)
  );
endmodule

// File: rtl/mdio_c45_checker.sv
module mdio_c45_checker
  import mdio_c45_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mdc,
  input logic               mdio_o,
  input logic               mdio_oe,
  input logic               active,
  input logic [1:0]         cur_op,
  input logic [IDX_W-1:0]   bit_idx,
  input logic [DIV_W-1:0]   div,
  input logic [PHYAD_W-1:0] pa,
  input logic [DEVAD_W-1:0] da
);
  logic           mdc_d;
  logic [DIV_W:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_d <= 1'b0;
      hold  <= '0;
    end else begin
      mdc_d <= mdc;
      if (!active)          hold <= '0;
      else if (mdc != mdc_d) hold <= (DIV_W+1)'(1);
      else                  hold <= hold + 1'b1;
    end
  end

  assert_mdc_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mdc);

  assert_mdc_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mdc != mdc_d) |-> (hold == {1'b0, div} + 1'b1));

  assert_change_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && mdio_o != $past(mdio_o)) |-> ($past(mdc) && !mdc));

  assert_release_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mdc) && active && cur_op == 2'b11 && bit_idx >= IDX_W'(TA1_IDX)) |-> !mdio_oe);

  assert_drive_header_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bit_idx < IDX_W'(TA1_IDX)) |-> mdio_oe);

  assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> ($stable(div) && $stable(pa) && $stable(da)));
endmodule

bind mdio_c45_master mdio_c45_checker #(.DIV_W(DIV_W)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .mdc    (mdc),
  .mdio_o (mdio_o),
  .mdio_oe(mdio_oe),
  .active (eng_active),
  .cur_op (eng_op),
  .bit_idx(eng_idx),
  .div    (div_q),
  .pa     (pa_q),
  .da     (da_q)
);

// File: tb/mdio_c45_master_tb_top.sv
module mdio_c45_master_tb_top;
  localparam int DIV_W = 8;
  localparam logic [7:0] DIV_RST = 8'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        phy_oe = 1'b0, phy_drv = 1'b1;
  logic        line;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign line = mdio_oe ? mdio_o : (phy_oe ? phy_drv : 1'b1);

  mdio_c45_master #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(line)
  );

  function automatic logic [15:0] phy_val(logic [4:0] p, logic [4:0] d, logic [15:0] r);
    return r ^ {p, d, 6'h15};
  endfunction

  // PHY model; PHY address 31 is absent
  int          ones = 0, hcnt = 0, k = 0, frame_cnt = 0, pre_seen = 0;
  logic        in_frame = 1'b0;
  logic [12:0] hdr;
  logic [17:0] tail;
  logic [15:0] ptr = '0;
  logic [1:0]  f_op, f_ta;
  logic [4:0]  f_pa, f_da;
  logic [15:0] f_pay;
  int          f_pre = 0;
  int          contention = 0, r7_viol = 0;
  time         t_prev = 0, mdc_per = 0;

  always @(posedge mdc) begin
    mdc_per = $time - t_prev;
    t_prev  = $time;
    if (!in_frame) begin
      if (line) ones++;
      else if (ones >= 32) begin in_frame = 1'b1; pre_seen = ones; hcnt = 1; k = 0; end
      else ones = 0;
    end else if (hcnt < 14) begin
      hdr = {hdr[11:0], line};
      hcnt++;
    end else begin
      k++;
      tail = {tail[16:0], line};
      if (k == 18) begin
        f_op = hdr[11:10]; f_pa = hdr[9:5]; f_da = hdr[4:0];
        f_ta = tail[17:16]; f_pay = tail[15:0]; f_pre = pre_seen;
        if (f_op == 2'b00) ptr = f_pay;
        frame_cnt++;
        in_frame = 1'b0;
        ones = 0;
      end
    end
  end

  always @(negedge mdc) begin
    if (in_frame && hcnt == 14 && hdr[11:10] == 2'b11 && hdr[9:5] != 5'd31 && k >= 1 && k <= 17) begin
      phy_oe  = 1'b1;
      phy_drv = (k == 1) ? 1'b0 : phy_val(hdr[9:5], hdr[4:0], ptr)[17-k];
    end else begin
      phy_oe  = 1'b0;
      phy_drv = 1'b1;
    end
  end

  logic p_oe = 1'b0, p_o = 1'b0, p_mdc = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mdio_oe && phy_oe) contention++;
      if (mdio_oe && p_oe && mdio_o != p_o && !(p_mdc && !mdc)) r7_viol++;
    end
    p_oe = mdio_oe; p_o = mdio_o; p_mdc = mdc;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s, dd;
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      rd(2'd0, s); rd(2'd3, dd);
      if (!s[0] && !dd[31]) break;
    end
  endtask

  function automatic logic [31:0] ctl(logic [4:0] p, logic [4:0] d, logic r);
    return {r, 10'd0, d, 11'd0, p};
  endfunction

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int fc;
    void'($urandom(32'h5eed_c45));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(2'd0, v); chk("R1 status", v, {16'd0, DIV_RST, 8'd0});
    rd(2'd3, v); chk("R1 data busy", {31'd0, v[31]}, 32'd0);
    chk("R1 mdc/oe", {30'd0, mdc, mdio_oe}, 32'd0);
    // R11
    wr(2'd0, 32'h0000_0300);
    rd(2'd0, v); chk("R11 divider", {24'd0, v[15:8]}, 32'd3);
    // R2 address frame
    wr(2'd1, ctl(5'd5, 5'd1, 1'b0));
    wr(2'd2, 32'h0000_1234);
    rd(2'd0, v); chk("R2 status busy", {31'd0, v[0]}, 32'd1);
    rd(2'd3, v); chk("R2 data not busy", {31'd0, v[31]}, 32'd0);
    wait_idle();
    chk("R2 frame", {f_op, 1'b0, f_pa, 3'd0, f_da, f_pay}, {2'b00, 1'b0, 5'd5, 3'd0, 5'd1, 16'h1234});
    chk("R5 preamble", f_pre, 32);
    chk("R5 turnaround", {30'd0, f_ta}, 32'd2);
    chk("R6 mdc period", 32'(mdc_per), 32'(2 * (3 + 1) * 20));
    chk("R6 mdc idle", {31'd0, mdc}, 32'd0);
    // R3 write frame
    wr(2'd3, 32'h0000_BEEF);
    rd(2'd3, v); chk("R3 data busy", {31'd0, v[31]}, 32'd1);
    rd(2'd0, v); chk("R3 status not busy", {31'd0, v[0]}, 32'd0);
    wait_idle();
    chk("R3 frame", {14'd0, f_op, f_pay}, {14'd0, 2'b01, 16'hBEEF});
    chk("R5 write ta", {30'd0, f_ta}, 32'd2);
    // R10 ignored accesses during a frame
    fc = frame_cnt;
    wr(2'd2, 32'h0000_1234);
    wr(2'd0, 32'h0000_0700);
    wr(2'd1, ctl(5'd9, 5'd9, 1'b1));
    wr(2'd3, 32'h0000_5555);
    wr(2'd2, 32'h0000_9999);
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R10 frame count", frame_cnt - fc, 1);
    chk("R10 last payload", {16'd0, f_pay}, 32'h1234);
    rd(2'd0, v); chk("R10 divider kept", {24'd0, v[15:8]}, 32'd3);
    rd(2'd1, v); chk("R10 control kept", v, ctl(5'd5, 5'd1, 1'b0));
    rd(2'd3, v); chk("R10 data kept", v, 32'h0000_BEEF);
    rd(2'd2, v); chk("R10 raddr kept", v, 32'h0000_1234);
    // R4 read
    wr(2'd1, ctl(5'd5, 5'd1, 1'b1));
    rd(2'd3, v); chk("R4 data busy", {31'd0, v[31]}, 32'd1);
    wait_idle();
    rd(2'd3, v); chk("R4 read data", v, {16'd0, phy_val(5'd5, 5'd1, 16'h1234)});
    chk("R4 read opcode", {30'd0, f_op}, 32'd3);
    rd(2'd0, v); chk("R9 no error", {31'd0, v[1]}, 32'd0);
    chk("R8 no contention", contention, 0);
    // R9 absent device
    wr(2'd1, ctl(5'd31, 5'd1, 1'b1));
    wait_idle();
    rd(2'd0, v); chk("R9 error set", {31'd0, v[1]}, 32'd1);
    wr(2'd0, 32'h0000_0300);
    rd(2'd0, v); chk("R9 error sticky", {31'd0, v[1]}, 32'd1);
    wr(2'd1, ctl(5'd5, 5'd1, 1'b1));
    rd(2'd0, v); chk("R9 cleared at read start", {31'd0, v[1]}, 32'd0);
    wait_idle();
    rd(2'd3, v); chk("R9 following read data", v, {16'd0, phy_val(5'd5, 5'd1, 16'h1234)});
    // random mix
    for (int it = 0; it < 24; it++) begin
      logic [4:0] p, d;
      logic [15:0] ra, val;
      logic [7:0] dv;
      p = 5'($urandom_range(0, 30)); d = 5'($urandom);
      ra = 16'($urandom); val = 16'($urandom); dv = 8'($urandom_range(0, 5));
      if (it == 0) begin ra = 16'hFFFF; val = 16'h0000; dv = 8'd0; end
      wr(2'd0, {16'd0, dv, 8'd0});
      wr(2'd1, ctl(p, d, 1'b0));
      wr(2'd2, {16'd0, ra});
      wait_idle();
      chk("R2 random addr frame", {f_op, 1'b0, f_pa, 3'd0, f_da, f_pay}, {2'b00, 1'b0, p, 3'd0, d, ra});
      chk("R6 random period", 32'(mdc_per), 32'(2 * (dv + 1) * 20));
      if ($urandom_range(0, 1) == 1) begin
        wr(2'd3, {16'd0, val});
        wait_idle();
        chk("R3 random write", {14'd0, f_op, f_pay}, {14'd0, 2'b01, val});
      end else begin
        wr(2'd1, ctl(p, d, 1'b1));
        wait_idle();
        rd(2'd3, v); chk("R4 random read", v, {16'd0, phy_val(p, d, ra)});
        rd(2'd0, v); chk("R9 random no error", {31'd0, v[1]}, 32'd0);
      end
    end
    chk("R8 contention total", contention, 0);
    chk("R7 change only after fall", r7_viol, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule